// File: doc/BRIEF.md
# UART Receive FIFO with Trigger-Level Interrupt

This block buffers bytes arriving from a UART deserializer until the host fetches them through the receive data register. It is a circular buffer of sixteen byte slots, tracked by a read pointer and an occupancy count. A new byte lands in the slot that lies `count` places after the read pointer, wrapping around the storage. The deserializer offers bytes with a valid/ready handshake. The register bank raises a one-cycle read strobe whenever the host reads the data register, and during that strobe the byte at the read pointer is presented combinationally.

The block produces three status outputs for the register bank: an empty flag, a full flag and a raw receive interrupt. A line-control bit selects the usable depth: sixteen slots when buffering is on, and a single slot when it is off. A separate control bit can make every accepted byte raise the full flag. The raw interrupt follows a trigger level that defaults to one. It is raised when a byte makes the count equal the trigger, and it is dropped when a read leaves the count one below the trigger. At the default level of one, the interrupt therefore means "data waiting".

When a read and a push occur in the same cycle, the read is applied first and the push second, and the count is updated once. The empty flag is driven by a small occupancy state machine with three states: `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_BRIMFUL`. Its transitions are:

- FIRST_ARRIVAL: `OCC_EMPTY` to `OCC_PARTIAL` on an accepted push.
- TOP_REACHED: `OCC_PARTIAL` to `OCC_BRIMFUL` when the count reaches the storage depth.
- SPACE_OPENED: `OCC_BRIMFUL` to `OCC_PARTIAL` on a read.
- LAST_DRAINED: `OCC_PARTIAL` to `OCC_EMPTY` when a read leaves no byte.

All other cycles hold the current state.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `rx_empty` is 1, `rx_full` is 0, `rx_irq_raw` is 0 and `push_ready` is 1.
- R2: `push_ready` is 1 exactly when the count is below 16 with `fifo_mode_en`=1, or below 1 with `fifo_mode_en`=0. A byte is stored only when `push_valid` and `push_ready` are both 1 at a clock edge.
- R3: Bytes are returned in the order they were accepted, including across the wrap from slot 15 to slot 0. An accepted push drives `rx_empty` to 0 at the next edge.
- R4: An accepted push sets `rx_full` if it brings the count to 16, or if `full_on_each_push` is 1.
- R5: A cycle with `host_rd`=1 shows the byte at the read pointer on `rd_data`. If the buffer holds data, that edge removes the byte and advances the pointer. If no push is accepted in the same cycle, `rx_full` is 0 after that edge.
- R6: A read that leaves the count at 0, with no push accepted in the same cycle, sets `rx_empty` at that edge.
- R7: `rx_irq_raw` is set when a push makes the count equal the trigger level (default 1), and cleared when a read leaves the count at trigger minus one. At the default level it equals the inverse of `rx_empty`.
- R8: A read while empty shows the stale byte at the read pointer and changes nothing: the pointer, count, `rx_empty` and `rx_irq_raw` stay as they were, and `rx_full` is 0 afterwards.
- R9: With a read and a push in the same cycle, the read is applied first and then the push. At count 1 the interrupt and the non-empty state stay set. At count 16 the push is refused and `rx_full` clears.
- R10: Clearing `fifo_mode_en` while more than one byte is held drops `push_ready` in the same cycle, with no edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode_en | input | 1 | Line-control buffering enable (16-deep when 1, 1-deep when 0) |
| full_on_each_push | input | 1 | Control bit: every accepted byte raises the full flag |
| push_valid | input | 1 | Deserializer offers a byte |
| push_data | input | 8 | Offered byte |
| push_ready | output | 1 | Space available for the offered byte |
| host_rd | input | 1 | One-cycle strobe for a host read of the data register |
| rd_data | output | 8 | Byte at the read pointer |
| rx_empty | output | 1 | Receive-empty flag |
| rx_full | output | 1 | Receive-full flag |
| rx_irq_raw | output | 1 | Raw receive interrupt |

## Verification
The hardest situation to reach is a read of an empty buffer right after a complete wrap. In that case the stale slot under the pointer holds a known older byte, and the bench can check that nothing moves. To get there, the stimulus places one byte in single-slot mode, which leaves the pointer at slot 1. It then fills all sixteen slots, drains them, and issues a read while empty. The returned byte must be the first of the sixteen. A follow-up push and read then confirm that the pointer did not advance. Same-cycle read and push are driven both at a count of one and at a full buffer. This exercises the read-then-push ordering in both its interrupt form and its full-flag form.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;

    // Occupancy classes tracked by the status state machine
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_BRIMFUL = 2'd2
    } occ_state_t;

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_addr] <= wr_data;
        end
    end

    assign rd_data = slots[rd_addr];

endmodule

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl #(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push_valid,
    input  logic             pop_req,
    output logic             push_ready,
    output logic             push_fire,
    output logic             pop_take,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_after_pop,
    output logic [CNT_W-1:0] cnt_next
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] SINGLE_C = CNT_W'(1);
    localparam logic [PTR_W-1:0] LAST_P   = PTR_W'(DEPTH - 1);

    logic [SUM_W-1:0] slot_sum;
    logic [PTR_W-1:0] rd_ptr_d;

    // Usable depth depends on the line-control buffering bit
    assign push_ready = fifo_en ? (cnt_q < DEPTH_C) : (cnt_q < SINGLE_C);
    assign push_fire  = push_valid && push_ready;
    assign pop_take   = pop_req && (cnt_q != '0);

    // Read is applied first, then the push
    assign cnt_after_pop = cnt_q - CNT_W'(pop_take);
    assign cnt_next      = cnt_after_pop + CNT_W'(push_fire);

    // Write slot is pointer plus count, modulo the storage depth
    assign slot_sum = SUM_W'(rd_ptr) + SUM_W'(cnt_q);
    assign wr_ptr   = (slot_sum >= SUM_W'(DEPTH)) ? PTR_W'(slot_sum - SUM_W'(DEPTH))
                                                  : PTR_W'(slot_sum);

    always_comb begin
        rd_ptr_d = rd_ptr;
        if (pop_take) begin
            rd_ptr_d = (rd_ptr == LAST_P) ? '0 : rd_ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            rd_ptr <= rd_ptr_d;
            cnt_q  <= cnt_next;
        end
    end

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
    import uart_rx_fifo_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TRIG_LEVEL = 1,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_req,
    input  logic             push_fire,
    input  logic             full_on_each_push,
    input  logic [CNT_W-1:0] cnt_after_pop,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             rx_irq_raw
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] TRIG_C  = CNT_W'(TRIG_LEVEL);
    localparam logic [CNT_W-1:0] TRIG_M1 = CNT_W'(TRIG_LEVEL - 1);

    occ_state_t state_q, state_d;
    logic       full_q, full_d;
    logic       irq_q, irq_d;

    // Next-state selection for the occupancy machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_fire) begin                    // FIRST_ARRIVAL
                    state_d = (cnt_next == DEPTH_C) ? OCC_BRIMFUL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (cnt_next == '0) begin               // LAST_DRAINED
                    state_d = OCC_EMPTY;
                end else if (cnt_next == DEPTH_C) begin // TOP_REACHED
                    state_d = OCC_BRIMFUL;
                end
            end
            OCC_BRIMFUL: begin
                if (cnt_next != DEPTH_C) begin          // SPACE_OPENED
                    state_d = OCC_PARTIAL;
                end
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // Flag updates: read effects first, push effects override
    always_comb begin
        full_d = full_q;
        irq_d  = irq_q;
        if (pop_req) begin
            full_d = 1'b0;
            if (cnt_after_pop == TRIG_M1) begin
                irq_d = 1'b0;
            end
        end
        if (push_fire) begin
            if ((cnt_next == DEPTH_C) || full_on_each_push) begin
                full_d = 1'b1;
            end
            if (cnt_next == TRIG_C) begin
                irq_d = 1'b1;
            end
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            full_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            full_q  <= full_d;
            irq_q   <= irq_d;
        end
    end

    // Output process
    always_comb begin
        rx_empty   = (state_q == OCC_EMPTY);
        rx_full    = full_q;
        rx_irq_raw = irq_q;
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 16,
    parameter int TRIG_LEVEL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode_en,
    input  logic              full_on_each_push,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              host_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_irq_raw
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_fire;
    logic             pop_take;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_after_pop;
    logic [CNT_W-1:0] cnt_next;

    rxf_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_en       (fifo_mode_en),
        .push_valid    (push_valid),
        .pop_req       (host_rd),
        .push_ready    (push_ready),
        .push_fire     (push_fire),
        .pop_take      (pop_take),
        .rd_ptr        (rd_ptr),
        .wr_ptr        (wr_ptr),
        .cnt_q         (cnt_q),
        .cnt_after_pop (cnt_after_pop),
        .cnt_next      (cnt_next)
    );

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .wr_en   (push_fire),
        .wr_addr (wr_ptr),
        .wr_data (push_data),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    rxf_flags #(.DEPTH(DEPTH), .TRIG_LEVEL(TRIG_LEVEL)) flags_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .pop_req           (host_rd),
        .push_fire         (push_fire),
        .full_on_each_push (full_on_each_push),
        .cnt_after_pop     (cnt_after_pop),
        .cnt_next          (cnt_next),
        .rx_empty          (rx_empty),
        .rx_full           (rx_full),
        .rx_irq_raw        (rx_irq_raw)
    );

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 16,
    parameter int TRIG_LEVEL = 1,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_mode_en,
    input logic              full_on_each_push,
    input logic              push_valid,
    input logic              push_ready,
    input logic              host_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic              rx_empty,
    input logic              rx_full,
    input logic              rx_irq_raw,
    input logic [CNT_W-1:0]  cnt_q
);

    // R2
    single_slot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode_en && !rx_empty) |-> !push_ready);

    // R2
    deep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(DEPTH)) |-> !push_ready);

    // R3
    push_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready) |=> !rx_empty);

    // R4
    forced_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && full_on_each_push) |=> rx_full);

    // R5
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !(push_valid && push_ready)) |=> !rx_full);

    // R6
    drain_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (cnt_q == CNT_W'(1)) && !(push_valid && push_ready)) |=> rx_empty);

    // R8
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && rx_empty && !push_valid) |=> ($stable(rd_data) && rx_empty && !rx_irq_raw));

    generate
        if (TRIG_LEVEL == 1) begin : g_unit_trig
            // R7
            irq_tracks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rx_irq_raw == !rx_empty);
        end
    endgenerate

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(
    .DATA_W     (DATA_W),
    .DEPTH      (DEPTH),
    .TRIG_LEVEL (TRIG_LEVEL)
) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .fifo_mode_en      (fifo_mode_en),
    .full_on_each_push (full_on_each_push),
    .push_valid        (push_valid),
    .push_ready        (push_ready),
    .host_rd           (host_rd),
    .rd_data           (rd_data),
    .rx_empty          (rx_empty),
    .rx_full           (rx_full),
    .rx_irq_raw        (rx_irq_raw),
    .cnt_q             (cnt_q)
);

// File: tb/uart_rx_fifo_tb_top.sv
`timescale 1ns/1ps
module uart_rx_fifo_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode_en = 1'b0;
    logic       full_on_each_push = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       push_ready;
    logic       host_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rx_empty;
    logic       rx_full;
    logic       rx_irq_raw;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [7:0] sb_q[$];

    always #10 clk = ~clk;

    uart_rx_fifo dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .fifo_mode_en      (fifo_mode_en),
        .full_on_each_push (full_on_each_push),
        .push_valid        (push_valid),
        .push_data         (push_data),
        .push_ready        (push_ready),
        .host_rd           (host_rd),
        .rd_data           (rd_data),
        .rx_empty          (rx_empty),
        .rx_full           (rx_full),
        .rx_irq_raw        (rx_irq_raw)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: offers a byte, queues it if it is accepted
    task automatic offer(input logic [7:0] b);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = b;
        #8;
        if (push_ready) sb_q.push_back(b);
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic read_and_offer(input logic [7:0] b);
        @(negedge clk);
        host_rd    = 1'b1;
        push_valid = 1'b1;
        push_data  = b;
        #8;
        if (push_ready) sb_q.push_back(b);
        @(negedge clk);
        host_rd    = 1'b0;
        push_valid = 1'b0;
    endtask

    // Monitor: compares every effective read against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #8;
            if (host_rd && !rx_empty) begin
                if (sb_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R3 R5: read %0h with nothing expected", rd_data);
                end else begin
                    check_eq("R3 R5 read order", int'(rd_data), int'(sb_q.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 empty", int'(rx_empty), 1);
        check_eq("R1 full", int'(rx_full), 0);
        check_eq("R1 irq", int'(rx_irq_raw), 0);
        check_eq("R1 ready", int'(push_ready), 1);

        // Single-slot mode
        offer(8'h5A);
        check_eq("R2 single-slot ready", int'(push_ready), 0);
        check_eq("R7 irq set", int'(rx_irq_raw), 1);
        check_eq("R3 empty cleared", int'(rx_empty), 0);
        check_eq("R4 no full at count 1", int'(rx_full), 0);
        offer(8'h77);                 // refused
        host_read();
        check_eq("R6 empty after drain", int'(rx_empty), 1);
        check_eq("R7 irq cleared", int'(rx_irq_raw), 0);

        // Sixteen-deep mode with wrap
        fifo_mode_en = 1'b1;
        for (int i = 0; i < 15; i++) offer(8'hA0 + 8'(i));
        check_eq("R4 not full at 15", int'(rx_full), 0);
        check_eq("R2 ready at 15", int'(push_ready), 1);
        offer(8'hAF);
        check_eq("R4 full at 16", int'(rx_full), 1);
        check_eq("R2 ready at 16", int'(push_ready), 0);
        offer(8'hEE);                 // refused
        host_read();
        check_eq("R5 full cleared by read", int'(rx_full), 0);
        for (int i = 0; i < 15; i++) host_read();
        check_eq("R6 empty after wrap drain", int'(rx_empty), 1);
        check_eq("R7 irq after wrap drain", int'(rx_irq_raw), 0);

        // Read while empty: stale slot 1 holds A0
        @(negedge clk);
        host_rd = 1'b1;
        #8;
        check_eq("R8 stale data", int'(rd_data), 8'hA0);
        @(negedge clk);
        host_rd = 1'b0;
        check_eq("R8 empty kept", int'(rx_empty), 1);
        check_eq("R8 irq kept", int'(rx_irq_raw), 0);
        check_eq("R8 full clear", int'(rx_full), 0);
        offer(8'h3C);
        host_read();                  // pointer unmoved: 3C comes back

        // Forced full and same-cycle read/push at count 1
        full_on_each_push = 1'b1;
        offer(8'h11);
        check_eq("R4 forced full", int'(rx_full), 1);
        full_on_each_push = 1'b0;
        read_and_offer(8'h22);
        check_eq("R9 full cleared", int'(rx_full), 0);
        check_eq("R9 irq kept", int'(rx_irq_raw), 1);
        check_eq("R9 not empty", int'(rx_empty), 0);
        host_read();
        check_eq("R6 empty again", int'(rx_empty), 1);

        // Mode switch drops ready at once
        for (int i = 0; i < 3; i++) offer(8'h40 + 8'(i));
        @(negedge clk);
        fifo_mode_en = 1'b0;
        #1;
        check_eq("R10 ready drop", int'(push_ready), 0);
        fifo_mode_en = 1'b1;
        #1;
        check_eq("R10 ready restore", int'(push_ready), 1);
        for (int i = 0; i < 3; i++) host_read();

        // Same-cycle read/push at full
        for (int i = 0; i < 16; i++) offer(8'hC0 + 8'(i));
        check_eq("R4 full before clash", int'(rx_full), 1);
        read_and_offer(8'h99);
        check_eq("R9 full cleared at top", int'(rx_full), 0);
        check_eq("R9 ready after clash", int'(push_ready), 1);
        for (int i = 0; i < 15; i++) host_read();
        check_eq("R6 final empty", int'(rx_empty), 1);
        check_eq("R3 scoreboard drained", sb_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule